// File: doc/BRIEF.md
# PCI Target Read Prefetch Controller

This block serves memory reads that arrive from the PCI side while the controller acts as a target. When a read starts, it issues burst requests on an internal bus master port. Each request asks for a fixed word count taken from a 2-bit length code. The returned 32-bit words are held in a small read FIFO and handed to the PCI master one per accepted beat. When the master ends the read, any words still held or still arriving are thrown away, so a later read never sees them.

A small configuration register sits in front of the datapath. It sets the burst length, turns prefetch off, and sets two diagnostic controls. The first control makes every target read end in a retry. The second makes every target read end in a target abort. With prefetch off, each fetch is a single word and the read disconnects on that word. The PCI and internal bus handshakes are simplified to valid/ready style strobes. Bus timing, arbitration, configuration space and writes are handled elsewhere.

Top module: `pci_tgt_prefetch`

## Requirements
- R1: Each internal request carries `b_len` = 2, 4, 6 or 8 words for `cfg_burst_code` 2'b00, 2'b01, 2'b10 or 2'b11, and exactly that many words are taken from the bus per grant.
- R2: After reset the length code is 2'b11 (8-word prefetch). Prefetch-off, force-retry and force-abort are 0. `t_valid`, `t_retry`, `t_abort` and `b_req` are low. Configuration fields change only in a cycle with `cfg_wr` high.
- R3: The k-th word delivered in a read started at `t_addr`=A (k from 0) is the word the bus returned for address A+4k. Each new request address follows on from the end of the previous burst.
- R4: When a read ends, the words that were fetched but not delivered are discarded. `t_valid` stays low until the next read, and the next read returns only its own data.
- R5: With prefetch off, every request is 1 word whatever the length code. The first word is delivered with `t_disc` high, that ends the read, and no second request is made.
- R6: With force-retry set and force-abort clear, a started read is answered by a one-cycle `t_retry` in the cycle after `t_start`, with no data and no bus request.
- R7: With force-abort set, a started read is answered by a one-cycle `t_abort` in the cycle after `t_start`, with no data and no bus request. This holds even if force-retry is also set.
- R8: A request is raised only when the FIFO has free room for the whole burst and no earlier burst is still outstanding. A master that does not accept data therefore stalls fetching once the FIFO is full.
- R9: A read started while leftover words of the previous read are still arriving is answered with `t_retry`, or with `t_abort` if force-abort is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the configuration fields below |
| cfg_burst_code | input | 2 | Prefetch length code |
| cfg_pf_off | input | 1 | Prefetch disable for the memory window |
| cfg_frc_retry | input | 1 | Diagnostic: retry every target read |
| cfg_frc_abort | input | 1 | Diagnostic: target-abort every target read |
| t_start | input | 1 | One-cycle start of a target memory read |
| t_addr | input | ADDR_W | Start address of the read |
| t_rdy | input | 1 | Master accepts a word this cycle |
| t_last | input | 1 | Master marks the beat it accepts as its final one |
| t_valid | output | 1 | A read word is offered |
| t_data | output | DATA_W | Offered read word |
| t_disc | output | 1 | Target disconnects with the offered word |
| t_retry | output | 1 | Retry termination pulse |
| t_abort | output | 1 | Target-abort termination pulse |
| b_req | output | 1 | Internal burst read request |
| b_addr | output | ADDR_W | Burst start address |
| b_len | output | 4 | Burst word count |
| b_gnt | input | 1 | Request accepted |
| b_dvalid | input | 1 | A returned burst word is valid |
| b_data | input | DATA_W | Returned burst word |

## Verification
A wrong word count or a skipped pointer shows up as a mismatch in `t_data` on the first affected beat. The bench's bus model returns each word's own address as its data, so a stale word left behind by a missing flush also appears in the first beat of the next read. A lost outstanding count shows up either as `b_req` staying low, which hangs the read, or as a request raised while the FIFO lacks room, visible within one burst of stalling the master. A corrupt termination path appears one cycle after `t_start` as the wrong pulse, or as data where none was due.

// File: rtl/prf_pkg.sv
package prf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2
  } prf_state_e;

  typedef struct packed {
    logic [1:0] burst_code;
    logic       pf_off;
    logic       frc_retry;
    logic       frc_abort;
  } prf_cfg_t;

  localparam logic [1:0] BURST_CODE_RST = 2'b11;
  localparam int unsigned MAX_BURST = 8;
endpackage

// File: rtl/prf_cfg.sv
module prf_cfg
  import prf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  prf_cfg_t wr_val,
  output prf_cfg_t cfg
);
  prf_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.burst_code <= BURST_CODE_RST;
      cfg_q.pf_off     <= 1'b0;
      cfg_q.frc_retry  <= 1'b0;
      cfg_q.frc_abort  <= 1'b0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(cfg_q));
endmodule

// File: rtl/prf_len_dec.sv
module prf_len_dec #(
  parameter int unsigned LEN_W = 4
) (
  input  logic [1:0]       code,
  input  logic             pf_off,
  output logic [LEN_W-1:0] words
);
  logic [LEN_W-1:0] coded;

  always_comb begin
    coded = LEN_W'({code, 1'b0}) + LEN_W'(2);
    words = pf_off ? LEN_W'(1) : coded;
  end
endmodule

// File: rtl/prf_fifo.sv
module prf_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic                             pop,
  input  logic                             flush,
  input  logic [DW-1:0]                    wdata,
  output logic [DW-1:0]                    rdata,
  output logic                             empty,
  output logic [$clog2(DEPTH+1)-1:0]       free
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    do_push = push && !flush;
    do_pop  = pop && !flush && (cnt_q != '0);
    wp_d    = wp_q;
    rp_d    = rp_q;
    cnt_d   = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = ptr_inc(wp_q);
      if (do_pop)  rp_d = ptr_inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign free  = CW'(DEPTH) - cnt_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |-> (int'(cnt_q) < DEPTH));
endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned CW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  prf_cfg_t          cfg,
  input  logic [LEN_W-1:0]  burst_words,
  input  logic              t_start,
  input  logic [ADDR_W-1:0] t_addr,
  input  logic              t_rdy,
  input  logic              t_last,
  output logic              t_valid,
  output logic              t_disc,
  output logic              t_retry,
  output logic              t_abort,
  output logic              b_req,
  output logic [ADDR_W-1:0] b_addr,
  output logic [LEN_W-1:0]  b_len,
  input  logic              b_gnt,
  input  logic              b_dvalid,
  input  logic              fifo_empty,
  input  logic [CW-1:0]     fifo_free,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic              fifo_flush
);
  prf_state_e        state_q, state_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic [LEN_W-1:0]  outst_q, outst_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              single_q, single_d;
  logic              fetched_q, fetched_d;
  logic              retry_q, retry_d;
  logic              abort_q, abort_d;
  logic              xfer, end_xfer, word_in, grant;

  always_comb begin
    t_valid  = (state_q == ST_XFER) && !fifo_empty;
    t_disc   = t_valid && single_q;
    xfer     = t_valid && t_rdy;
    end_xfer = xfer && (t_last || single_q);
    word_in  = b_dvalid && (outst_q != '0);
    b_req    = (state_q == ST_XFER) && (outst_q == '0) &&
               !(single_q && fetched_q) &&
               (int'(fifo_free) >= int'(len_q));
    grant    = b_req && b_gnt;

    fifo_push  = word_in && (state_q == ST_XFER);
    fifo_pop   = xfer;
    fifo_flush = end_xfer;

    state_d   = state_q;
    faddr_d   = faddr_q;
    len_d     = len_q;
    single_d  = single_q;
    fetched_d = fetched_q;
    retry_d   = 1'b0;
    abort_d   = 1'b0;

    outst_d = outst_q;
    if (grant) begin
      outst_d   = len_q;
      faddr_d   = faddr_q + (ADDR_W'(len_q) << 2);
      fetched_d = 1'b1;
    end else if (word_in) begin
      outst_d = outst_q - LEN_W'(1);
    end

    unique case (state_q)
      ST_IDLE: begin
        if (t_start) begin
          if (cfg.frc_abort) begin
            abort_d = 1'b1;
          end else if (cfg.frc_retry) begin
            retry_d = 1'b1;
          end else begin
            state_d   = ST_XFER;
            faddr_d   = t_addr;
            len_d     = burst_words;
            single_d  = cfg.pf_off;
            fetched_d = 1'b0;
          end
        end
      end
      ST_XFER: begin
        if (end_xfer) state_d = (outst_d != '0) ? ST_DRAIN : ST_IDLE;
      end
      ST_DRAIN: begin
        if (t_start) begin
          abort_d = cfg.frc_abort;
          retry_d = !cfg.frc_abort;
        end
        if (outst_d == '0) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      faddr_q   <= '0;
      outst_q   <= '0;
      len_q     <= '0;
      single_q  <= 1'b0;
      fetched_q <= 1'b0;
      retry_q   <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      faddr_q   <= faddr_d;
      outst_q   <= outst_d;
      len_q     <= len_d;
      single_q  <= single_d;
      fetched_q <= fetched_d;
      retry_q   <= retry_d;
      abort_q   <= abort_d;
    end
  end

  assign t_retry = retry_q;
  assign t_abort = abort_q;
  assign b_addr  = faddr_q;
  assign b_len   = len_q;

  // R6
  term_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({t_retry, t_abort, t_valid}));

  // R7
  abort_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t_retry |-> !$past(cfg.frc_abort));

  // R8
  room_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER) |-> (int'(fifo_free) >= int'(outst_q)));

  // R1
  len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_req |-> (b_len == 4'd1 || b_len == 4'd2 || b_len == 4'd4 ||
               b_len == 4'd6 || b_len == 4'd8));

  // R5
  single_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req && single_q) |-> (b_len == 4'd1));
endmodule

// File: rtl/pci_tgt_prefetch.sv
module pci_tgt_prefetch
  import prf_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_burst_code,
  input  logic              cfg_pf_off,
  input  logic              cfg_frc_retry,
  input  logic              cfg_frc_abort,
  input  logic              t_start,
  input  logic [ADDR_W-1:0] t_addr,
  input  logic              t_rdy,
  input  logic              t_last,
  output logic              t_valid,
  output logic [DATA_W-1:0] t_data,
  output logic              t_disc,
  output logic              t_retry,
  output logic              t_abort,
  output logic              b_req,
  output logic [ADDR_W-1:0] b_addr,
  output logic [3:0]        b_len,
  input  logic              b_gnt,
  input  logic              b_dvalid,
  input  logic [DATA_W-1:0] b_data
);
  localparam int unsigned LEN_W = $clog2(MAX_BURST + 1);
  localparam int unsigned CW    = $clog2(FIFO_DEPTH + 1);

  prf_cfg_t         wr_val, cfg;
  logic [LEN_W-1:0] burst_words;
  logic [LEN_W-1:0] len_int;
  logic             f_empty, f_push, f_pop, f_flush;
  logic [CW-1:0]    f_free;

  generate
    if (FIFO_DEPTH < MAX_BURST) begin : g_depth_bad
      initial $error("FIFO_DEPTH must hold the longest burst");
    end
  endgenerate

  always_comb begin
    wr_val.burst_code = cfg_burst_code;
    wr_val.pf_off     = cfg_pf_off;
    wr_val.frc_retry  = cfg_frc_retry;
    wr_val.frc_abort  = cfg_frc_abort;
  end

  prf_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr),
    .wr_val (wr_val),
    .cfg    (cfg)
  );

  prf_len_dec #(.LEN_W(LEN_W)) u_dec (
    .code   (cfg.burst_code),
    .pf_off (cfg.pf_off),
    .words  (burst_words)
  );

  prf_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (f_push),
    .pop   (f_pop),
    .flush (f_flush),
    .wdata (b_data),
    .rdata (t_data),
    .empty (f_empty),
    .free  (f_free)
  );

  prf_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .burst_words (burst_words),
    .t_start     (t_start),
    .t_addr      (t_addr),
    .t_rdy       (t_rdy),
    .t_last      (t_last),
    .t_valid     (t_valid),
    .t_disc      (t_disc),
    .t_retry     (t_retry),
    .t_abort     (t_abort),
    .b_req       (b_req),
    .b_addr      (b_addr),
    .b_len       (len_int),
    .b_gnt       (b_gnt),
    .b_dvalid    (b_dvalid),
    .fifo_empty  (f_empty),
    .fifo_free   (f_free),
    .fifo_push   (f_push),
    .fifo_pop    (f_pop),
    .fifo_flush  (f_flush)
  );

  assign b_len = 4'(len_int);
endmodule

// File: tb/pci_tgt_prefetch_tb.sv
module pci_tgt_prefetch_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_burst_code;
  logic        cfg_pf_off, cfg_frc_retry, cfg_frc_abort;
  logic        t_start;
  logic [31:0] t_addr;
  logic        t_rdy, t_last;
  logic        t_valid, t_disc, t_retry, t_abort;
  logic [31:0] t_data;
  logic        b_req;
  logic [31:0] b_addr;
  logic [3:0]  b_len;
  logic        b_gnt, b_dvalid;
  logic [31:0] b_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  int          bus_left = 0;
  logic [31:0] bus_addr = '0;
  int          n_bursts = 0;
  int          n_words  = 0;
  int          last_len = 0;
  int          bad_bus  = 0;

  int got;
  bit saw_retry, saw_abort, saw_disc;
  int stall_words;
  bit stall_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_tgt_prefetch u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_burst_code(cfg_burst_code),
    .cfg_pf_off(cfg_pf_off), .cfg_frc_retry(cfg_frc_retry), .cfg_frc_abort(cfg_frc_abort),
    .t_start(t_start), .t_addr(t_addr), .t_rdy(t_rdy), .t_last(t_last),
    .t_valid(t_valid), .t_data(t_data), .t_disc(t_disc), .t_retry(t_retry),
    .t_abort(t_abort), .b_req(b_req), .b_addr(b_addr), .b_len(b_len),
    .b_gnt(b_gnt), .b_dvalid(b_dvalid), .b_data(b_data)
  );

  // Internal bus model: data word equals its own address.
  always @(negedge clk) begin
    if (bus_left > 0) begin
      b_dvalid = 1'b1;
      b_data   = bus_addr;
      bus_addr = bus_addr + 32'd4;
      bus_left = bus_left - 1;
      n_words  = n_words + 1;
    end else begin
      b_dvalid = 1'b0;
    end
    if (b_req && bus_left == 0 && rst_n) begin
      b_gnt    = 1'b1;
      bus_left = int'(b_len);
      bus_addr = b_addr;
      last_len = int'(b_len);
      n_bursts = n_bursts + 1;
    end else begin
      b_gnt = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] code, input logic pfo, input logic rty, input logic abt);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_burst_code = code; cfg_pf_off = pfo;
    cfg_frc_retry = rty; cfg_frc_abort = abt;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && bus_left != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_stats();
    n_bursts = 0; n_words = 0; last_len = 0;
  endtask

  // Master side: read n words from addr, optional initial stall.
  task automatic pci_read(input string req, input logic [31:0] addr, input int n, input int stall);
    got = 0; saw_retry = 0; saw_abort = 0; saw_disc = 0;
    @(negedge clk);
    t_start = 1'b1; t_addr = addr; t_rdy = (stall == 0);
    @(negedge clk);
    t_start = 1'b0;
    if (stall > 0) begin
      if (t_retry) saw_retry = 1;
      if (t_abort) saw_abort = 1;
      repeat (stall) @(negedge clk);
      stall_words = n_words;
      stall_req   = b_req;
      t_rdy = 1'b1;
    end
    for (int cyc = 0; cyc < 300 && !saw_retry && !saw_abort; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (t_retry) begin saw_retry = 1; break; end
      if (t_abort) begin saw_abort = 1; break; end
      if (t_valid) begin
        check(req, t_data, addr + 32'(4 * got));
        t_last = (got == n - 1);
        if (t_disc) saw_disc = 1;
        got++;
        if (got == n || t_disc) begin
          @(negedge clk);
          break;
        end
      end else begin
        t_last = 1'b0;
      end
    end
    t_last = 1'b0; t_rdy = 1'b0;
  endtask

  task automatic t_reset();
    // R2
    check("R2 t_valid", 32'(t_valid), 0);
    check("R2 b_req", 32'(b_req), 0);
    check("R2 t_retry", 32'(t_retry), 0);
    check("R2 t_abort", 32'(t_abort), 0);
    clear_stats();
    pci_read("R2/R3 default read", 32'h1000, 3, 0);
    check("R2 default burst 8", 32'(last_len), 8);
    check("R2 words", 32'(got), 3);
    wait_idle();
    // R4
    check("R4 valid low after end", 32'(t_valid), 0);
    check("R4 leftovers fetched", 32'(n_words), 8);
  endtask

  task automatic t_no_stale();
    // R4
    clear_stats();
    pci_read("R4 fresh data", 32'h2000, 2, 0);
    check("R4 got", 32'(got), 2);
    wait_idle();
  endtask

  task automatic t_codes();
    // R1
    for (int c = 0; c < 3; c++) begin
      set_cfg(2'(c), 1'b0, 1'b0, 1'b0);
      clear_stats();
      pci_read("R1/R3 code read", 32'h3000 + 32'(c * 32'h100), 10, 0);
      check("R1 burst len", 32'(last_len), 32'(2 * c + 2));
      check("R3 full read", 32'(got), 10);
      wait_idle();
      check("R1 whole bursts", 32'(n_words % (2 * c + 2)), 0);
    end
  endtask

  task automatic t_stall();
    // R8
    set_cfg(2'b00, 1'b0, 1'b0, 1'b0);
    clear_stats();
    pci_read("R8/R3 stalled read", 32'h4000, 12, 30);
    check("R8 fill stops at depth", 32'(stall_words), 8);
    check("R8 no request when full", 32'(stall_req), 0);
    check("R8 read completes", 32'(got), 12);
    wait_idle();
  endtask

  task automatic t_single();
    // R5
    set_cfg(2'b10, 1'b1, 1'b0, 1'b0);
    clear_stats();
    pci_read("R5 single data", 32'h5000, 4, 0);
    check("R5 one word", 32'(got), 1);
    check("R5 disconnect", 32'(saw_disc), 1);
    repeat (5) @(negedge clk);
    check("R5 one request", 32'(n_bursts), 1);
    check("R5 length 1", 32'(last_len), 1);
    check("R5 valid low", 32'(t_valid), 0);
    wait_idle();
  endtask

  task automatic t_force();
    // R6
    set_cfg(2'b11, 1'b0, 1'b1, 1'b0);
    clear_stats();
    pci_read("R6 retry data", 32'h6000, 2, 0);
    check("R6 retry seen", 32'(saw_retry), 1);
    check("R6 no data", 32'(got), 0);
    check("R6 no fetch", 32'(n_bursts), 0);
    // R7
    set_cfg(2'b11, 1'b0, 1'b0, 1'b1);
    pci_read("R7 abort data", 32'h6100, 2, 0);
    check("R7 abort seen", 32'(saw_abort), 1);
    check("R7 no retry", 32'(saw_retry), 0);
    set_cfg(2'b11, 1'b0, 1'b1, 1'b1);
    pci_read("R7 both data", 32'h6200, 2, 0);
    check("R7 abort wins", 32'(saw_abort), 1);
    check("R7 retry suppressed", 32'(saw_retry), 0);
    check("R7 no fetch", 32'(n_bursts), 0);
    set_cfg(2'b11, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_drain_retry();
    // R9
    clear_stats();
    pci_read("R9 first read", 32'h7000, 1, 0);
    pci_read("R9 second read", 32'h7400, 2, 0);
    check("R9 retry while draining", 32'(saw_retry), 1);
    check("R9 no data", 32'(got), 0);
    wait_idle();
    pci_read("R9/R4 after drain", 32'h7800, 3, 0);
    check("R9 later read ok", 32'(got), 3);
    wait_idle();
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_burst_code = 2'b00; cfg_pf_off = 1'b0;
    cfg_frc_retry = 1'b0; cfg_frc_abort = 1'b0; t_start = 1'b0; t_addr = '0;
    t_rdy = 1'b0; t_last = 1'b0; b_gnt = 1'b0; b_dvalid = 1'b0; b_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_stale();
    t_codes();
    t_stall();
    t_single();
    t_force();
    t_drain_retry();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule